// File: doc/BRIEF.md
# Sprite Attribute Memory with Page-Copy DMA

This block holds the 256-byte sprite attribute store and gives the processor three register ports for it. The first port loads the sprite address pointer. The second port reads or writes the byte the pointer selects. The third port starts a burst copy. A write to the third port takes the written byte as the upper half of a processor-space address. The block then fetches the 256 bytes of that page in ascending order and stores them into sprite memory.

The burst has a fixed rhythm. Each byte uses two cycles: one cycle drives a read request to the processor bus, and the next cycle stores the returned byte. A whole page therefore takes 512 cycles. The stored bytes land at the current sprite pointer, which advances after every byte and wraps from 0xFF to 0x00. The pointer is back at its starting value when the burst ends. For the whole burst the block asserts a hold output that keeps the processor off the bus, and it ignores all register traffic.

Top module: `sprite_attr_dma`

## Requirements
- R1: After reset, bus_hold, mem_rd_en and reg_rvalid are 0 and the sprite pointer is 0, so a data-port write issued before any pointer write lands at location 0.
- R2: A write with reg_sel = 0 loads the sprite pointer from reg_wdata. The reg_sel encoding is 0 = pointer, 1 = data port, 2 = DMA trigger, 3 = unused.
- R3: A write with reg_sel = 1 stores reg_wdata at the pointed location and then increments the pointer, wrapping from 0xFF to 0x00.
- R4: A read with reg_sel = 1 presents the pointed byte on reg_rdata with reg_rvalid high in the following cycle, and it leaves the pointer unchanged.
- R5: A write of value P with reg_sel = 2 makes the block fetch addresses P*256 through P*256+255 in ascending order. The page part of mem_addr stays fixed during the burst.
- R6: Each byte slot is a read cycle (mem_rd_en high) followed by a write cycle (mem_rd_en low). The byte on mem_rdata during the write cycle is the byte that gets stored.
- R7: Byte k of the burst is stored at (S+k) mod 256, where S is the pointer value when the trigger arrives. The pointer equals S again when the burst ends.
- R8: bus_hold rises in the cycle after the trigger and stays high for exactly 512 cycles.
- R9: While bus_hold is high, every register write (pointer, data and trigger) and every data-port read is ignored, and no reg_rvalid is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 2 | Register select: 0 pointer, 1 data, 2 DMA trigger |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Data-port read result |
| reg_rvalid | output | 1 | reg_rdata is valid this cycle |
| mem_rd_en | output | 1 | Read request towards the processor bus |
| mem_addr | output | 16 | Processor-space source address |
| mem_rdata | input | 8 | Read data, returned the cycle after mem_rd_en |
| bus_hold | output | 1 | Processor held off the bus while a burst runs |

## Verification
A pointer that drifts shows up as a shifted copy. The byte the bench reads back at the start location is then a neighbouring source byte, and the error is visible on the first read after the burst. A wrong slot or page counter shows up on the bus one slot after the fault, as an out-of-order or out-of-page mem_addr, or as a hold window that is not 512 cycles long. A lockout that leaks during the burst shows up as an unexpected reg_rvalid, an extra fetch, or a displaced byte once the burst completes.

// File: rtl/sad_pkg.sv
package sad_pkg;
  typedef enum logic [1:0] {
    SEL_PTR  = 2'd0,
    SEL_DATA = 2'd1,
    SEL_DMA  = 2'd2,
    SEL_NONE = 2'd3
  } sad_sel_e;
endpackage

// File: rtl/sad_ram.sv
module sad_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // single port, read-first, registered output: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/sad_dma.sv
module sad_dma #(
  parameter int AW = 8,
  parameter int PW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [PW-1:0]    start_page,
  output logic             busy,
  output logic             rd_en,
  output logic             wr_en,
  output logic [PW+AW-1:0] src_addr
);
  logic          wr_phase;
  logic [AW-1:0] cnt;
  logic [PW-1:0] page;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      wr_phase <= 1'b0;
      cnt      <= '0;
      page     <= '0;
    end else if (!busy) begin
      wr_phase <= 1'b0;
      cnt      <= '0;
      if (start) begin
        busy <= 1'b1;
        page <= start_page;
      end
    end else begin
      wr_phase <= ~wr_phase;
      if (wr_phase) begin
        cnt <= cnt + 1'b1;
        if (cnt == {AW{1'b1}}) busy <= 1'b0;
      end
    end
  end

  assign rd_en    = busy & ~wr_phase;
  assign wr_en    = busy & wr_phase;
  assign src_addr = {page, cnt};
endmodule

// File: rtl/sprite_attr_dma.sv
module sprite_attr_dma #(
  parameter int AW     = 8,
  parameter int DW     = 8,
  parameter int CPU_AW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_sel,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              reg_rvalid,
  output logic              mem_rd_en,
  output logic [CPU_AW-1:0] mem_addr,
  input  logic [DW-1:0]     mem_rdata,
  output logic              bus_hold
);
  import sad_pkg::*;

  localparam int PW = CPU_AW - AW;

  logic          busy, dma_rd, dma_wr;
  logic          ptr_wr, data_wr, data_rd, trig;
  logic [AW-1:0] ptr;
  logic          ram_we;
  logic [DW-1:0] ram_wdata;
  sad_sel_e      sel;

  assign sel     = sad_sel_e'(reg_sel);
  assign ptr_wr  = !busy && reg_wr && sel == SEL_PTR;
  assign data_wr = !busy && reg_wr && sel == SEL_DATA;
  assign trig    = !busy && reg_wr && sel == SEL_DMA;
  assign data_rd = !busy && reg_rd && sel == SEL_DATA;

  sad_dma #(.AW(AW), .PW(PW)) i_dma (
    .clk        (clk),
    .rst        (rst),
    .start      (trig),
    .start_page (reg_wdata[PW-1:0]),
    .busy       (busy),
    .rd_en      (dma_rd),
    .wr_en      (dma_wr),
    .src_addr   (mem_addr)
  );

  // the pointer doubles as DMA destination
  always_ff @(posedge clk) begin
    if (rst)                    ptr <= '0;
    else if (ptr_wr)            ptr <= reg_wdata[AW-1:0];
    else if (data_wr || dma_wr) ptr <= ptr + 1'b1;
  end

  assign ram_we    = data_wr | dma_wr;
  assign ram_wdata = dma_wr ? mem_rdata : reg_wdata;

  sad_ram #(.AW(AW), .DW(DW)) i_ram (
    .clk   (clk),
    .we    (ram_we),
    .re    (data_rd),
    .addr  (ptr),
    .wdata (ram_wdata),
    .rdata (reg_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) reg_rvalid <= 1'b0;
    else     reg_rvalid <= data_rd;
  end

  assign mem_rd_en = dma_rd;
  assign bus_hold  = busy;
endmodule

// File: rtl/sad_checker.sv
module sad_checker #(
  parameter int AW     = 8,
  parameter int CPU_AW = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [1:0]        reg_sel,
  input logic              reg_rvalid,
  input logic              mem_rd_en,
  input logic [CPU_AW-1:0] mem_addr,
  input logic              bus_hold
);
  import sad_pkg::*;

  localparam logic [AW+1:0] FULL = (AW+2)'(2 ** (AW + 1));

  logic [AW+1:0] hold_cnt;

  always_ff @(posedge clk) begin
    if (rst)           hold_cnt <= '0;
    else if (bus_hold) hold_cnt <= hold_cnt + 1'b1;
    else               hold_cnt <= '0;
  end

  a_r1_idle_no_fetch: assert property (@(posedge clk) disable iff (rst)
    !bus_hold |-> !mem_rd_en);

  a_r8_hold_rises: assert property (@(posedge clk) disable iff (rst)
    (!bus_hold && reg_wr && reg_sel == SEL_DMA) |=> bus_hold);

  a_r8_hold_length: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_hold) |-> hold_cnt == FULL);

  a_r6_read_then_write: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> (bus_hold && !mem_rd_en));

  a_r6_write_then_read: assert property (@(posedge clk) disable iff (rst)
    (bus_hold && !mem_rd_en) |=> (mem_rd_en || !bus_hold));

  a_r5_page_fixed: assert property (@(posedge clk) disable iff (rst)
    (bus_hold && $past(bus_hold)) |-> $stable(mem_addr[CPU_AW-1:AW]));

  a_r9_no_read_return: assert property (@(posedge clk) disable iff (rst)
    $past(bus_hold) |-> !reg_rvalid);
endmodule

bind sprite_attr_dma sad_checker #(.AW(AW), .CPU_AW(CPU_AW)) i_sad_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_wr     (reg_wr),
  .reg_sel    (reg_sel),
  .reg_rvalid (reg_rvalid),
  .mem_rd_en  (mem_rd_en),
  .mem_addr   (mem_addr),
  .bus_hold   (bus_hold)
);

// File: tb/test_sprite_attr_dma.sv
module test_sprite_attr_dma;
  localparam logic [1:0] S_PTR  = 2'd0;
  localparam logic [1:0] S_DATA = 2'd1;
  localparam logic [1:0] S_DMA  = 2'd2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_sel = 2'd3;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        reg_rvalid;
  logic        mem_rd_en;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata = '0;
  logic        bus_hold;

  int errors = 0;
  int checks = 0;
  int hold_run = 0;
  int hold_last = 0;

  logic [7:0]  model [256];
  logic [7:0]  m_ptr = '0;
  logic [7:0]  rd_q [$];
  logic [15:0] fetch_q [$];

  always #4 clk = ~clk;

  sprite_attr_dma i_sprite_attr_dma (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .bus_hold(bus_hold)
  );

  function automatic logic [7:0] src(input logic [15:0] a);
    return (a[7:0] * 8'd7) ^ (a[15:8] + 8'h3C);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bus slave: data returned one cycle after the request
  always @(posedge clk) if (mem_rd_en) mem_rdata <= src(mem_addr);

  // monitors
  always @(negedge clk) begin
    if (!rst && reg_rvalid) begin
      if (rd_q.size() == 0) chk(0, "R9 unexpected rvalid", 1, 0);
      else begin
        automatic logic [7:0] e = rd_q.pop_front();
        chk(reg_rdata == e, "R4/R7 read data", reg_rdata, e);
      end
    end
    if (!rst && mem_rd_en) begin
      if (fetch_q.size() == 0) chk(0, "R9 unexpected fetch", mem_addr, 0);
      else begin
        automatic logic [15:0] e = fetch_q.pop_front();
        chk(mem_addr == e, "R5 fetch address", mem_addr, e);
      end
    end
    if (bus_hold) hold_run++;
    else if (hold_run != 0) begin
      hold_last = hold_run;
      hold_run = 0;
    end
  end

  task automatic wr(input logic [1:0] s, input logic [7:0] d, input bit track);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    if (track) begin
      if (s == S_PTR) m_ptr = d;
      else if (s == S_DATA) begin model[m_ptr] = d; m_ptr = m_ptr + 8'd1; end
    end
    @(negedge clk);
    reg_wr = 1'b0; reg_sel = 2'd3;
  endtask

  task automatic rd(input bit expect_data);
    @(negedge clk);
    reg_rd = 1'b1; reg_sel = S_DATA;
    if (expect_data) rd_q.push_back(model[m_ptr]);
    @(negedge clk);
    reg_rd = 1'b0; reg_sel = 2'd3;
  endtask

  task automatic rd_at(input logic [7:0] a);
    wr(S_PTR, a, 1);
    rd(1);
  endtask

  task automatic dma(input logic [7:0] page, input bit disturb);
    automatic logic [7:0] start = m_ptr;
    for (int i = 0; i < 256; i++) fetch_q.push_back({page, 8'(i)});
    wr(S_DMA, page, 0);
    // trigger edge passed one half-cycle ago
    chk(bus_hold == 1'b1, "R8 hold rises after trigger", bus_hold, 1);
    if (disturb) begin
      wr(S_DMA, 8'h55, 0);   // R9 trigger ignored
      wr(S_PTR, 8'h00, 0);   // R9 pointer write ignored
      wr(S_DATA, 8'h99, 0);  // R9 data write ignored
      rd(0);                 // R9 read ignored
    end
    for (int i = 0; i < 2000 && bus_hold; i++) @(negedge clk);
    @(negedge clk);
    chk(hold_last == 512, "R8 hold length", hold_last, 512);
    chk(fetch_q.size() == 0, "R5 all bytes fetched", fetch_q.size(), 0);
    for (int i = 0; i < 256; i++) model[8'(start + 8'(i))] = src({page, 8'(i)});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(bus_hold == 1'b0, "R1 hold idle", bus_hold, 0);
    chk(mem_rd_en == 1'b0, "R1 no fetch", mem_rd_en, 0);
    chk(reg_rvalid == 1'b0, "R1 no rvalid", reg_rvalid, 0);

    // R1: pointer resets to 0
    wr(S_DATA, 8'hA5, 1);
    rd_at(8'h00);

    // R2, R3: pointer load and post-increment
    wr(S_PTR, 8'h40, 1);
    wr(S_DATA, 8'h11, 1);
    wr(S_DATA, 8'h22, 1);
    wr(S_DATA, 8'h33, 1);
    rd_at(8'h40);
    rd_at(8'h41);
    rd_at(8'h42);

    // R4: reads leave pointer unchanged
    rd(1);
    rd(1);

    // R3: wrap of the data-port pointer
    wr(S_PTR, 8'hFF, 1);
    wr(S_DATA, 8'h5A, 1);
    wr(S_DATA, 8'hC3, 1);
    rd_at(8'hFF);
    rd_at(8'h00);

    // R5..R9: burst from a mid pointer, disturbed while busy
    wr(S_PTR, 8'hF0, 1);
    dma(8'h12, 1);
    rd(1);                  // R7: pointer back at start
    for (int a = 0; a < 256; a++) rd_at(8'(a));

    // second burst from pointer 0, page 0
    wr(S_PTR, 8'h00, 1);
    dma(8'h00, 0);
    rd_at(8'h00);
    rd_at(8'h7F);
    rd_at(8'hFF);

    repeat (4) @(negedge clk);
    chk(rd_q.size() == 0, "R4 all reads returned", rd_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule